// File: doc/BRIEF.md
# Master/Slave Synchronised Clock Generator

This block derives the timing clocks of a receiver from one 40 MHz input clock. In master mode it produces a sample clock at the input clock divided by seven, with a nominal half-and-half duty cycle. It also produces a 20 MHz companion clock that a second device uses to align its divider phase with the master. The companion clock stays low for a fixed 200 ns (eight input cycles) after reset is released, and then toggles on every rising edge.

In slave mode the sample clock and the companion clock output stay low, and the companion pad is turned around to act as an input. The slave's divider is held at a preset phase. That preset is the phase the master's divider reaches on the rising edge where the companion clock first goes high. On the first low-to-high transition seen on the incoming companion clock, the slave starts counting. From that edge onward its phase matches the master's.

The control is a three-state machine:
- HOLD: master, counting out the release delay.
- ARM: slave, waiting for the companion clock.
- RUN: dividing and running.

Reset enters HOLD when `master_i` is 1, and ARM when it is 0. The named transitions are:
- DELAY_DONE: HOLD to RUN, once eight cycles have been counted.
- EDGE_SEEN: ARM to RUN, on a detected rising edge of `sclk_i`.

RUN is left only through reset. `master_i` is a strap and must change only while reset is asserted.

Top module: `clkgen_sync`

## Requirements
- R1: While `rst_i` is high, the following hold at every rising clock edge: `sclk_o`, `samp_clk_o` and `locked_o` are 0. `phase_o` is 0 in master mode and 2 in slave mode.
- R2: In master mode, `sclk_o` and `locked_o` stay 0 for the first 8 rising edges after reset is released. Both become 1 at the 9th rising edge.
- R3: In master mode, once `locked_o` is 1, `sclk_o` inverts at every rising edge.
- R4: In master mode, `samp_clk_o` has a period of 7 input cycles. It rises at the falling edge that follows the rising edge where `phase_o` becomes 0. It falls at the rising edge where `phase_o` becomes 4. This gives 3.5 cycles high and 3.5 cycles low.
- R5: In master mode, `phase_o` advances by one modulo 7 at every rising edge after reset release, starting from 0. It reads 1 after the first edge.
- R6: In slave mode, `samp_clk_o`, `sclk_o` and `sclk_oe_o` are always 0. In master mode, `sclk_oe_o` is 1.
- R7: In slave mode, `phase_o` holds at 2 and `locked_o` is 0 until a rising edge of the clock samples `sclk_i` as 1 after having sampled it as 0 at the previous rising edge. At that edge `phase_o` becomes 3 and `locked_o` becomes 1. After that edge `phase_o` advances by one modulo 7 per edge.
- R8: A slave whose `sclk_i` is fed by a master's `sclk_o`, with both released from reset together, locks at the 10th edge after release. From that edge its `phase_o` equals the master's.
- R9: A `sclk_i` that is already high at reset release is not an edge. The slave stays in ARM until it has sampled `sclk_i` low and then high.
- R10: Asserting reset in RUN returns the block to its reset state. After the next release, the full 8-cycle delay (master) or the wait for the companion clock (slave) applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| master_i | input | 1 | 1 selects master mode, 0 selects slave mode (static outside reset) |
| sclk_i | input | 1 | Companion clock from the pad (used in slave mode) |
| samp_clk_o | output | 1 | Sample clock, input clock divided by 7 |
| sclk_o | output | 1 | Companion 20 MHz clock toward the pad |
| sclk_oe_o | output | 1 | Pad output enable for the companion clock |
| phase_o | output | 3 | Current divider phase, 0 to 6 |
| locked_o | output | 1 | 1 while the state machine is in RUN |

## Verification
A wrong state or delay count shows at once on `locked_o`, and on `sclk_o` at the 9th edge: one edge early or late breaks the expected toggle pattern in that cycle. A divider phase that is off by any amount shows on `phase_o` at the next edge, and on `samp_clk_o` within seven cycles. A slave that misses the edge or takes a false one shows within one cycle: `phase_o` disagrees with the linked master, or `locked_o` is set too early. The bench samples `samp_clk_o` in both halves of every input cycle, so a lost half-cycle in the duty shaping is caught within one sample period.

// File: rtl/clkgen_sync_pkg.sv
package clkgen_sync_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } cg_state_e;
endpackage

// File: rtl/clkgen_sync_fsm.sv
module clkgen_sync_fsm
    import clkgen_sync_pkg::*;
#(
    parameter int DLY_CYC = 8
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      master_i,
    input  logic      sclk_i,
    output cg_state_e state_o,
    output logic      adv_o,
    output logic      sclk_o
);
    localparam int CW = $clog2(DLY_CYC + 1);

    cg_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          sin_q;
    logic          sin_rise;

    assign sin_rise = sclk_i & ~sin_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (cnt_q == CW'(DLY_CYC)) state_d = ST_RUN;  // DELAY_DONE
            ST_ARM:  if (sin_rise) state_d = ST_RUN;               // EDGE_SEEN
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= master_i ? ST_HOLD : ST_ARM;
        else       state_q <= state_d;
    end

    // Registered outputs: delay counter, companion clock, input history
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            sin_q  <= 1'b1;
        end else begin
            sin_q <= sclk_i;
            if (state_q == ST_HOLD && cnt_q != CW'(DLY_CYC))
                cnt_q <= cnt_q + 1'b1;
            if (master_i) begin
                if (state_q == ST_HOLD && state_d == ST_RUN) sclk_q <= 1'b1;
                else if (state_q == ST_RUN)                  sclk_q <= ~sclk_q;
            end
        end
    end

    assign adv_o   = (state_q == ST_HOLD) || (state_q == ST_RUN) ||
                     (state_q == ST_ARM && sin_rise);
    assign state_o = state_q;
    assign sclk_o  = sclk_q;
endmodule

// File: rtl/clkgen_sync_phase.sv
module clkgen_sync_phase #(
    parameter int DIV     = 7,
    parameter int PRELOAD = 2,
    localparam int PW     = $clog2(DIV)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          master_i,
    input  logic          adv_i,
    output logic [PW-1:0] phase_o,
    output logic [PW-1:0] phase_nxt_o
);
    logic [PW-1:0] phase_q;

    always_comb begin
        phase_nxt_o = phase_q;
        if (adv_i) phase_nxt_o = (phase_q == PW'(DIV - 1)) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) phase_q <= master_i ? '0 : PW'(PRELOAD);
        else       phase_q <= phase_nxt_o;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/clkgen_sync_duty.sv
module clkgen_sync_duty #(
    parameter int DIV      = 7,
    localparam int PW      = $clog2(DIV),
    localparam int HI_PH   = (DIV + 1) / 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic [PW-1:0] phase_nxt_i,
    output logic          samp_o
);
    logic hi_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) hi_q <= 1'b0;
        else       hi_q <= en_i && (phase_nxt_i < PW'(HI_PH));
    end

    generate
        if (DIV % 2 == 1) begin : g_odd
            logic lo_q;
            // Half-cycle delayed copy trims the high time by half a cycle
            always_ff @(negedge clk_i) lo_q <= hi_q;
            assign samp_o = hi_q & lo_q;
        end else begin : g_even
            assign samp_o = hi_q;
        end
    endgenerate
endmodule

// File: rtl/clkgen_sync.sv
module clkgen_sync
    import clkgen_sync_pkg::*;
#(
    parameter int DIV     = 7,
    parameter int DLY_CYC = 8,
    localparam int PW     = $clog2(DIV)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          master_i,
    input  logic          sclk_i,
    output logic          samp_clk_o,
    output logic          sclk_o,
    output logic          sclk_oe_o,
    output logic [PW-1:0] phase_o,
    output logic          locked_o
);
    localparam int PRELOAD = (DLY_CYC + 1) % DIV;

    cg_state_e     state;
    logic          adv;
    logic          sclk_int;
    logic [PW-1:0] phase_nxt;

    clkgen_sync_fsm #(.DLY_CYC(DLY_CYC)) u_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .master_i (master_i),
        .sclk_i   (sclk_i),
        .state_o  (state),
        .adv_o    (adv),
        .sclk_o   (sclk_int)
    );

    clkgen_sync_phase #(.DIV(DIV), .PRELOAD(PRELOAD)) u_phase (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .master_i    (master_i),
        .adv_i       (adv),
        .phase_o     (phase_o),
        .phase_nxt_o (phase_nxt)
    );

    clkgen_sync_duty #(.DIV(DIV)) u_duty (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (master_i),
        .phase_nxt_i (phase_nxt),
        .samp_o      (samp_clk_o)
    );

    assign sclk_o    = sclk_int & master_i;
    assign sclk_oe_o = master_i;
    assign locked_o  = (state == ST_RUN);
endmodule

// File: rtl/clkgen_sync_chk.sv
module clkgen_sync_chk #(
    parameter int DIV     = 7,
    parameter int DLY_CYC = 8,
    localparam int PW     = $clog2(DIV)
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          master_i,
    input logic          samp_clk_o,
    input logic          sclk_o,
    input logic          sclk_oe_o,
    input logic [PW-1:0] phase_o,
    input logic          locked_o
);
    localparam int PRELOAD = (DLY_CYC + 1) % DIV;
    localparam int HI_PH   = (DIV + 1) / 2;

    logic rst_seen;
    int   rel_cnt;

    always_ff @(posedge clk_i) begin
        rst_seen <= rst_i;
        if (rst_i)                    rel_cnt <= 0;
        else if (rel_cnt < DLY_CYC+2) rel_cnt <= rel_cnt + 1;
    end

    always @(negedge clk_i) begin
        if (rst_seen) begin
            AST_RESET_QUIET: assert (!sclk_o && !samp_clk_o && !locked_o &&
                (phase_o == (master_i ? PW'(0) : PW'(PRELOAD)))); // R1
        end
    end

    AST_DELAY_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (master_i && $rose(locked_o)) |-> (rel_cnt == DLY_CYC + 1)); // R2
    AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (master_i && !locked_o) |-> !sclk_o); // R2
    AST_SCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (master_i && locked_o && $past(locked_o)) |-> (sclk_o != $past(sclk_o))); // R3
    AST_SAMP_SHAPE: assert property (@(posedge clk_i) disable iff (rst_i)
        (master_i && locked_o) |-> (samp_clk_o == (phase_o < PW'(HI_PH)))); // R4
    AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (locked_o && $past(locked_o)) |->
        (phase_o == (($past(phase_o) == PW'(DIV-1)) ? PW'(0) : $past(phase_o) + 1'b1))); // R5
    AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !master_i |-> (!sclk_o && !samp_clk_o && !sclk_oe_o)); // R6
    AST_ARM_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!master_i && !locked_o) |-> (phase_o == PW'(PRELOAD))); // R7
endmodule

bind clkgen_sync clkgen_sync_chk #(.DIV(DIV), .DLY_CYC(DLY_CYC)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .master_i   (master_i),
    .samp_clk_o (samp_clk_o),
    .sclk_o     (sclk_o),
    .sclk_oe_o  (sclk_oe_o),
    .phase_o    (phase_o),
    .locked_o   (locked_o)
);

// File: tb/clkgen_sync_bench.sv
`timescale 1ns/1ps
module clkgen_sync_bench;
    localparam real CLK_PERIOD = 25.0;
    localparam int  DIV = 7;
    localparam int  DLY = 8;
    localparam int  PRE = 2;
    localparam int  HI  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link = 1'b1;
    logic tb_sclk = 1'b0;
    logic restarted = 1'b0;
    logic s_in;

    logic       m_samp, m_sclk, m_oe, m_lock;
    logic [2:0] m_phase;
    logic       s_samp, s_sclk, s_oe, s_lock;
    logic [2:0] s_phase;

    int nchk = 0;
    int nfail = 0;
    int n = 0;
    int lk = -1;
    int s_prev = 1;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    assign s_in = link ? m_sclk : tb_sclk;

    clkgen_sync u_clkgen_sync (
        .clk_i(clk), .rst_i(rst), .master_i(1'b1), .sclk_i(1'b0),
        .samp_clk_o(m_samp), .sclk_o(m_sclk), .sclk_oe_o(m_oe),
        .phase_o(m_phase), .locked_o(m_lock)
    );

    clkgen_sync u_clkgen_sync_slv (
        .clk_i(clk), .rst_i(rst), .master_i(1'b0), .sclk_i(s_in),
        .samp_clk_o(s_samp), .sclk_o(s_sclk), .sclk_oe_o(s_oe),
        .phase_o(s_phase), .locked_o(s_lock)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int hi_at(input int k);
        return (k >= 1 && (k % DIV) < HI) ? 1 : 0;
    endfunction

    // Behavioural reference: edges since release and slave lock edge
    always @(posedge clk) begin
        if (rst) begin
            n = 0; lk = -1; s_prev = 1;
        end else begin
            n = n + 1;
            if (lk < 0 && s_in == 1'b1 && s_prev == 0) lk = n;
            s_prev = int'(s_in);
        end
    end

    // Clock-high samples
    always @(posedge clk) begin
        #(CLK_PERIOD/4.0);
        begin
            int e_lock, e_sclk, e_sph, e_slk;
            string t_lk, t_ph, t_s;
            e_lock = (n >= DLY + 1) ? 1 : 0;
            e_sclk = (e_lock == 1 && ((n - DLY - 1) % 2 == 0)) ? 1 : 0;
            t_lk = (n == 0) ? "R1" : (restarted ? "R10" : "R2");
            t_ph = (n == 0) ? "R1" : "R5";
            t_s  = (n == 0) ? "R1" : (link ? "R7" : "R9");
            chk(t_lk, int'(m_lock), e_lock);
            chk((n > DLY + 1) ? "R3" : t_lk, int'(m_sclk), e_sclk);
            chk(t_ph, int'(m_phase), n % DIV);
            chk((n == 0) ? "R1" : "R4", int'(m_samp), hi_at(n) & hi_at(n - 1));
            chk("R6", int'(m_oe), 1);
            chk("R6", int'(s_oe), 0);
            chk("R6", int'(s_sclk), 0);
            chk("R6", int'(s_samp), 0);
            e_slk = (lk >= 0) ? 1 : 0;
            e_sph = (lk < 0) ? PRE : (PRE + 1 + n - lk) % DIV;
            chk(t_s, int'(s_lock), e_slk);
            chk(t_s, int'(s_phase), e_sph);
            if (link && lk >= 0) begin
                chk("R8", lk, DLY + 2);
                chk("R8", int'(s_phase), int'(m_phase));
            end
        end
    end

    // Clock-low samples of the sample clock
    always @(negedge clk) begin
        #(CLK_PERIOD/4.0);
        chk("R4", int'(m_samp), hi_at(n));
        chk("R6", int'(s_samp), 0);
    end

    initial begin
        #(CLK_PERIOD * 20000.0);
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R1/R2/R8: linked pair from reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (70) @(negedge clk);
        // R9: companion input high across release, then low, then high
        rst = 1'b1; link = 1'b0; tb_sclk = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (15) @(negedge clk);
        tb_sclk = 1'b0;
        repeat (3) @(negedge clk);
        tb_sclk = 1'b1;
        repeat (2) @(negedge clk);
        tb_sclk = 1'b0;
        repeat (25) @(negedge clk);
        // R10: reset while running restarts the delay and the lock
        rst = 1'b1; link = 1'b1; restarted = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (50) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule